// File: doc/BRIEF.md
# Indexed DAC PLL programming sequencer

This block converts a requested pixel-clock period, given in picoseconds, into the two divider bytes of an external clock synthesiser. It then loads them, together with a fixed set of setup values, through an 8-bit indexed register port. One `start_i` pulse carries the period. A seven-entry threshold table selects the divider pair. A request longer than every threshold is rejected with an error pulse, and no bus traffic is issued for it.

A programming run consists of eight indexed register writes. Each indexed write uses five single-byte bus transfers:

1. Open the extended index mode on the control port.
2. Send the low index byte.
3. Send the high index byte.
4. Send the value.
5. Close the mode on the control port.

A ready input can stall the transfers. A one-cycle done pulse marks the end of the run.

Top module: `dac_pll_seq`

## Requirements
- R1: After reset, `bus_we_o`, `done_o` and `err_o` are all 0.
- R2: Each indexed write is five strobes on consecutive ready cycles, with port select 0 = control, 1 = index low, 2 = index high, 3 = data. The strobes are: select 0 with data 0x01, then select 1 with the index bits 7:0, then select 2 with the index bits 15:8, then select 3 with the value, then select 0 with data 0x00.
- R3: A run performs eight indexed writes in this order: 0x0006←0x02, 0x0010←0x01, 0x0070←0x01, 0x008F←0x1F, 0x0003←0x00, 0x0005←0x00, 0x0020←M, 0x0021←N. That is 40 strobes in total.
- R4: The table maps period limits to (M, N) as follows: 8000→(0xD4, 9), 10000→(0x53, 3), 13000→(0x42, 3), 14000→(0x88, 7), 16000→(0x6C, 6), 25000→(0x4F, 5), 50000→(0x35, 7). The first entry whose limit is greater than or equal to the period is used, so a period equal to a limit selects that entry.
- R5: M carries the post-divide select in bits 7:6 and the VCO divide count in bits 5:0. It is written unmodified as the value for index 0x0020.
- R6: A period above 50000 gives `err_o` high for exactly one cycle, the cycle after the start, and no bus strobe at all.
- R7: While `bus_rdy_i` is low, no strobe is issued, and `bus_sel_o` and `bus_data_o` hold their values. The run resumes where it stopped.
- R8: A `start_i` that arrives while a run is in progress is ignored. The run in progress completes unchanged, and no second run follows.
- R9: `done_o` is high for exactly one cycle, the cycle after the 40th strobe. `done_o` and `err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, sampled when idle |
| period_i | input | 16 | Requested pixel period in ps |
| bus_rdy_i | input | 1 | Bus can accept a strobe this cycle |
| bus_we_o | output | 1 | One-cycle write strobe |
| bus_sel_o | output | 2 | Port select (0 ctrl, 1 idx lo, 2 idx hi, 3 data) |
| bus_data_o | output | 8 | Write data byte |
| done_o | output | 1 | Run finished pulse |
| err_o | output | 1 | No table match pulse |

## Verification
On every cycle, the assertions check four things:

- select and data stay stable through a stall;
- done is a single cycle and always follows a strobe;
- done and error never coincide;
- an error cycle carries no strobe.

Only the bench's scenarios can show the rest. These are:

- the full 40-strobe content and its order;
- the table boundaries at and just past each chosen limit;
- the rejection of an over-range period;
- that a second start during a run leaves the traffic unchanged.

// File: rtl/dac_pll_pkg.sv
package dac_pll_pkg;
  localparam int NUM_ENTRIES = 7;
  localparam int NUM_ITEMS   = 8;
  localparam int ITEM_W      = $clog2(NUM_ITEMS);
  localparam int STEPS       = 5;
  localparam int STEP_W      = $clog2(STEPS);

  typedef enum logic [1:0] {
    PORT_CTRL   = 2'd0,
    PORT_IDX_LO = 2'd1,
    PORT_IDX_HI = 2'd2,
    PORT_DATA   = 2'd3
  } port_e;

  function automatic logic [31:0] lut_limit(input logic [2:0] e);
    case (e)
      3'd0:    return 32'd8000;
      3'd1:    return 32'd10000;
      3'd2:    return 32'd13000;
      3'd3:    return 32'd14000;
      3'd4:    return 32'd16000;
      3'd5:    return 32'd25000;
      default: return 32'd50000;
    endcase
  endfunction

  // {post_div[1:0], vco_count[5:0]}
  function automatic logic [7:0] lut_m(input logic [2:0] e);
    case (e)
      3'd0:    return {2'd3, 6'd20};
      3'd1:    return {2'd1, 6'd19};
      3'd2:    return {2'd1, 6'd2};
      3'd3:    return {2'd2, 6'd8};
      3'd4:    return {2'd1, 6'd44};
      3'd5:    return {2'd1, 6'd15};
      default: return {2'd0, 6'd53};
    endcase
  endfunction

  function automatic logic [7:0] lut_n(input logic [2:0] e);
    case (e)
      3'd0:    return 8'd9;
      3'd1:    return 8'd3;
      3'd2:    return 8'd3;
      3'd3:    return 8'd7;
      3'd4:    return 8'd6;
      3'd5:    return 8'd5;
      default: return 8'd7;
    endcase
  endfunction

  function automatic logic [15:0] item_index(input logic [2:0] i);
    case (i)
      3'd0:    return 16'h0006;
      3'd1:    return 16'h0010;
      3'd2:    return 16'h0070;
      3'd3:    return 16'h008F;
      3'd4:    return 16'h0003;
      3'd5:    return 16'h0005;
      3'd6:    return 16'h0020;
      default: return 16'h0021;
    endcase
  endfunction

  function automatic logic [7:0] item_value(input logic [2:0] i,
                                            input logic [7:0] m,
                                            input logic [7:0] n);
    case (i)
      3'd0:    return 8'h02;
      3'd1:    return 8'h01;
      3'd2:    return 8'h01;
      3'd3:    return 8'h1F;
      3'd4:    return 8'h00;
      3'd5:    return 8'h00;
      3'd6:    return m;
      default: return n;
    endcase
  endfunction
endpackage

// File: rtl/period_lut.sv
module period_lut
  import dac_pll_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic [PERIOD_W-1:0] period_i,
  output logic                hit_o,
  output logic [7:0]          m_o,
  output logic [7:0]          n_o
);
  logic [NUM_ENTRIES-1:0] fits;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    assign fits[e] = 32'(period_i) <= lut_limit(3'(e));
  end

  // lowest index wins
  always_comb begin
    m_o = '0;
    n_o = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
      if (fits[e]) begin
        m_o = lut_m(3'(e));
        n_o = lut_n(3'(e));
      end
    end
  end

  assign hit_o = |fits;
endmodule

// File: rtl/idx_writer.sv
module idx_writer
  import dac_pll_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        rdy_i,
  input  logic [15:0] index_i,
  input  logic [7:0]  value_i,
  output logic        we_o,
  output logic [1:0]  sel_o,
  output logic [7:0]  data_o,
  output logic        last_o
);
  logic [STEP_W-1:0] step_q;

  assign we_o   = en_i && rdy_i;
  assign last_o = we_o && (step_q == STEP_W'(STEPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     step_q <= '0;
    else if (last_o) step_q <= '0;
    else if (we_o)   step_q <= step_q + 1'b1;
  end

  always_comb begin
    case (step_q)
      STEP_W'(0): begin sel_o = PORT_CTRL;   data_o = 8'h01;         end
      STEP_W'(1): begin sel_o = PORT_IDX_LO; data_o = index_i[7:0];  end
      STEP_W'(2): begin sel_o = PORT_IDX_HI; data_o = index_i[15:8]; end
      STEP_W'(3): begin sel_o = PORT_DATA;   data_o = value_i;       end
      default:    begin sel_o = PORT_CTRL;   data_o = 8'h00;         end
    endcase
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !rdy_i |=> $stable(sel_o) && $stable(data_o));
endmodule

// File: rtl/dac_pll_seq.sv
module dac_pll_seq
  import dac_pll_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                bus_rdy_i,
  output logic                bus_we_o,
  output logic [1:0]          bus_sel_o,
  output logic [7:0]          bus_data_o,
  output logic                done_o,
  output logic                err_o
);
  logic              hit;
  logic [7:0]        lut_m_w, lut_n_w;
  logic              run_q, done_q, err_q, last_w;
  logic [ITEM_W-1:0] item_q;
  logic [7:0]        m_q, n_q;

  period_lut #(.PERIOD_W(PERIOD_W)) u_lut (
    .period_i (period_i),
    .hit_o    (hit),
    .m_o      (lut_m_w),
    .n_o      (lut_n_w)
  );

  idx_writer u_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (run_q),
    .rdy_i   (bus_rdy_i),
    .index_i (item_index(item_q)),
    .value_i (item_value(item_q, m_q, n_q)),
    .we_o    (bus_we_o),
    .sel_o   (bus_sel_o),
    .data_o  (bus_data_o),
    .last_o  (last_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      item_q <= '0;
      m_q    <= '0;
      n_q    <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!run_q && start_i) begin
        if (hit) begin
          run_q  <= 1'b1;
          item_q <= '0;
          m_q    <= lut_m_w;
          n_q    <= lut_n_w;
        end else begin
          err_q <= 1'b1;
        end
      end else if (run_q && last_w) begin
        if (item_q == ITEM_W'(NUM_ITEMS - 1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          item_q <= item_q + 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;

  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  done_after_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(bus_we_o));
  // R9
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  // R6
  err_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !bus_we_o);
endmodule

// File: tb/dac_pll_seq_test.sv
module dac_pll_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] period = '0;
  logic        rdy = 1'b1;
  logic        we, done, err;
  logic [1:0]  sel;
  logic [7:0]  data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int wcount = 0;
  int done_cnt = 0;
  int err_cnt = 0;
  bit stall_mode = 0;
  logic [1:0] log_sel [64];
  logic [7:0] log_dat [64];

  always #10 clk = ~clk;

  dac_pll_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .period_i(period),
    .bus_rdy_i(rdy), .bus_we_o(we), .bus_sel_o(sel), .bus_data_o(data),
    .done_o(done), .err_o(err)
  );

  // monitor at negedge: outputs stable mid-cycle
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (we) begin
        if (wcount < 64) begin
          log_sel[wcount] = sel;
          log_dat[wcount] = data;
        end
        wcount++;
      end
      if (done) done_cnt++;
      if (err) err_cnt++;
    end
  end

  // ready pattern, changed just after posedge
  always @(posedge clk) begin
    #2 rdy = stall_mode ? ((cyc % 3) != 1) && ((cyc % 7) != 3) : 1'b1;
  end

  always @(negedge clk) begin
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_idx(input int i);
    case (i)
      0: return 16'h0006; 1: return 16'h0010; 2: return 16'h0070;
      3: return 16'h008F; 4: return 16'h0003; 5: return 16'h0005;
      6: return 16'h0020; default: return 16'h0021;
    endcase
  endfunction

  function automatic logic [7:0] exp_val(input int i, input logic [7:0] m,
                                         input logic [7:0] n);
    case (i)
      0: return 8'h02; 1: return 8'h01; 2: return 8'h01; 3: return 8'h1F;
      4: return 8'h00; 5: return 8'h00; 6: return m; default: return n;
    endcase
  endfunction

  task automatic clear_counts();
    wcount = 0; done_cnt = 0; err_cnt = 0;
  endtask

  task automatic pulse_start(input logic [15:0] p);
    @(posedge clk); #2;
    start = 1'b1; period = p;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (done_cnt != 0 || err_cnt != 0) break;
    end
    repeat (6) @(negedge clk);
  endtask

  // R2 R3 R5: compare the whole strobe log
  task automatic check_log(input string req, input logic [7:0] m,
                           input logic [7:0] n);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < 8; i++) begin
      logic [15:0] ix = exp_idx(i);
      logic [1:0] es [5];
      logic [7:0] ed [5];
      es[0] = 2'd0; ed[0] = 8'h01;
      es[1] = 2'd1; ed[1] = ix[7:0];
      es[2] = 2'd2; ed[2] = ix[15:8];
      es[3] = 2'd3; ed[3] = exp_val(i, m, n);
      es[4] = 2'd0; ed[4] = 8'h00;
      for (int s = 0; s < 5; s++) begin
        int w = i * 5 + s;
        if (w < wcount && (log_sel[w] != es[s] || log_dat[w] != ed[s])) begin
          bad++;
          if (first < 0) first = w;
        end
      end
    end
    check({req, " strobe count"}, wcount, 40);
    check({req, " mismatched strobes"}, bad, 0);
    if (first >= 0)
      $display("  first mismatch at strobe %0d sel=%0d data=%0h",
               first, log_sel[first], log_dat[first]);
    check({req, " M value"}, (wcount >= 34) ? int'(log_dat[33]) : -1, int'(m));
  endtask

  task automatic t_reset();
    check("R1 we", we, 0);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
  endtask

  task automatic t_run(input string req, input logic [15:0] p,
                       input logic [7:0] m, input logic [7:0] n);
    clear_counts();
    pulse_start(p);
    wait_end();
    check_log(req, m, n);
    check({req, " R9 done pulses"}, done_cnt, 1);
    check({req, " err pulses"}, err_cnt, 0);
  endtask

  task automatic t_nomatch(input logic [15:0] p);
    clear_counts();
    pulse_start(p);
    wait_end();
    check("R6 err pulses", err_cnt, 1);
    check("R6 strobes", wcount, 0);
    check("R6 done pulses", done_cnt, 0);
  endtask

  task automatic t_stall();
    stall_mode = 1;
    t_run("R7 stalled", 16'd15000, 8'h6C, 8'd6);
    stall_mode = 0;
    @(posedge clk); #2;
  endtask

  task automatic t_restart_ignored();
    clear_counts();
    pulse_start(16'd7000);
    repeat (10) @(posedge clk);
    #2 start = 1'b1; period = 16'd12000;
    @(posedge clk); #2 start = 1'b0;
    wait_end();
    repeat (60) @(negedge clk);
    check_log("R8 restart", 8'hD4, 8'd9);
    check("R8 done pulses", done_cnt, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run("R4 p0", 16'd0, 8'hD4, 8'd9);
    t_run("R4 at 8000", 16'd8000, 8'hD4, 8'd9);
    t_run("R4 8001", 16'd8001, 8'h53, 8'd3);
    t_run("R4 13500", 16'd13500, 8'h88, 8'd7);
    t_run("R4 25000", 16'd25000, 8'h4F, 8'd5);
    t_run("R4 at 50000", 16'd50000, 8'h35, 8'd7);
    t_nomatch(16'd50001);
    t_nomatch(16'hFFFF);
    t_stall();
    t_restart_ignored();
    t_run("R3 after restart", 16'd11000, 8'h42, 8'd3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule